// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches recent virtual-to-physical page translations. The address space uses 14-bit virtual addresses, 12-bit physical addresses and 64-byte pages, so an 8-bit virtual page number maps to a 6-bit physical page number. The cache holds sixteen translations in four sets of four ways. The two lowest page-number bits select the set. The remaining six bits are the tag stored with each entry. Every entry also keeps the read, write and execute permissions that came from its page-table entry.

A lookup port answers within the same cycle from registered storage. It returns a hit flag, the physical page number and the permission bits. When a lookup misses, outside logic walks the page table and writes the translation back through a fill port. The new entry can be seen from the next cycle on. A fill whose tag is already present in the set overwrites that entry. Otherwise the fill takes the lowest-numbered empty way. If the set is full, a round-robin pointer kept for each set chooses the way to replace. A flush input empties the whole array in one cycle when the active process changes.

Top module: `vpn_xlate_tlb`

## Requirements
- R1: After reset no lookup hits. Whenever a lookup misses, `lk_ppn` and `lk_perm` read zero.
- R2: The set index is VPN bits [1:0] and the tag is VPN bits [7:2]. Two translations with the same tag in different sets both stay resident.
- R3: A hit returns the stored PPN and the stored permissions, encoded as bit 2 = read, bit 1 = write, bit 0 = execute.
- R4: A fill written at a clock edge is returned by a lookup of the same VPN in the cycle that follows.
- R5: A lookup misses when no valid entry in its set carries its tag, even if that set holds other valid entries.
- R6: A fill into a set that has empty ways takes the lowest-numbered empty way, so four distinct fills into an empty set all stay resident.
- R7: A fill into a full set replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and steps by one, wrapping, after each such replacement. The oldest of four fills into an empty set is therefore evicted first, then the second oldest.
- R8: A fill whose tag already exists in its set overwrites that entry with the new PPN and permissions. No other entry is evicted and the set's pointer does not move.
- R9: A flush clears every entry and returns every round-robin pointer to way 0.
- R10: When a flush and a fill arrive in the same cycle, the flush wins and the fill is discarded.
- R11: A lookup is combinational: the outputs follow `lk_vpn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 8 | Virtual page number to look up |
| lk_hit | output | 1 | A valid matching entry was found |
| lk_ppn | output | 6 | Physical page number on a hit, zero on a miss |
| lk_perm | output | 3 | Read/write/execute permissions on a hit, zero on a miss |
| fl_en | input | 1 | Write one translation this cycle |
| fl_vpn | input | 8 | Virtual page number of the fill |
| fl_ppn | input | 6 | Physical page number of the fill |
| fl_perm | input | 3 | Permissions of the fill |
| flush_all | input | 1 | Invalidate the whole array |

## Verification
The bench fills one set past capacity twice in a row. A replacement policy that ignores the pointer, or never advances it, would then evict a translation that was filled more recently. It refills a resident tag in a full set. A design that allocated a new way would drop a neighbour or leave a stale duplicate, and a pointer that stepped on a refill would choose the wrong next victim. It also sends a flush together with a fill, and uses the same tag in different sets. A design that let the fill through, or indexed with the wrong bits, would report hits where none should exist.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    parameter int VPN_W    = 8;
    parameter int PPN_W    = 6;
    parameter int SET_BITS = 2;
    parameter int WAYS     = 4;
    localparam int SETS    = 1 << SET_BITS;
    localparam int TAG_W   = VPN_W - SET_BITS;
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } entry_t;

    function automatic logic [SET_BITS-1:0] set_of(input logic [VPN_W-1:0] vpn);
        return vpn[SET_BITS-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:SET_BITS];
    endfunction
endpackage

// File: rtl/tlb_way_match.sv
`timescale 1ns/1ps
module tlb_way_match
    import tlb_pkg::*;
(
    input  entry_t [WAYS-1:0] ways,
    input  logic [TAG_W-1:0]  tag,
    output logic [WAYS-1:0]   hit_vec,
    output logic              hit,
    output logic [PPN_W-1:0]  ppn,
    output perm_t             perm
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = ways[w].valid && (ways[w].tag == tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        ppn  = '0;
        perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                ppn  = ppn | ways[w].ppn;
                perm = perm | ways[w].perm;
            end
        end
    end
endmodule

// File: rtl/tlb_victim_pick.sv
`timescale 1ns/1ps
module tlb_victim_pick
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAYS-1:0]  match_vec,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] way,
    output logic             advance
);
    always_comb begin
        way     = rr_ptr;
        advance = 1'b0;
        if (|match_vec) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (match_vec[w]) way = WAY_W'(w);
            end
        end else if (!(&valid_vec)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!valid_vec[w]) way = WAY_W'(w);
            end
        end else begin
            advance = 1'b1;
        end
    end
endmodule

// File: rtl/vpn_xlate_tlb.sv
`timescale 1ns/1ps
module vpn_xlate_tlb
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [2:0]       lk_perm,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic [2:0]       fl_perm,
    input  logic             flush_all
);
    entry_t [WAYS-1:0] mem [SETS];
    logic [WAY_W-1:0]  rr_ptr [SETS];

    // lookup side
    logic [SET_BITS-1:0] lk_set;
    logic [WAYS-1:0]     lk_hit_vec;
    perm_t               lk_perm_s;

    assign lk_set = set_of(lk_vpn);

    tlb_way_match i_lk_match (
        .ways    (mem[lk_set]),
        .tag     (tag_of(lk_vpn)),
        .hit_vec (lk_hit_vec),
        .hit     (lk_hit),
        .ppn     (lk_ppn),
        .perm    (lk_perm_s)
    );
    assign lk_perm = lk_perm_s;

    // fill side
    logic [SET_BITS-1:0] fl_set;
    logic [WAYS-1:0]     fl_match_vec;
    logic [WAYS-1:0]     fl_valid_vec;
    logic                fl_any;
    logic [PPN_W-1:0]    fl_unused_ppn;
    perm_t               fl_unused_perm;
    logic [WAY_W-1:0]    fl_way;
    logic                fl_adv;
    entry_t              fl_entry;

    assign fl_set = set_of(fl_vpn);

    for (genvar w = 0; w < WAYS; w++) begin : g_valid
        assign fl_valid_vec[w] = mem[fl_set][w].valid;
    end

    tlb_way_match i_fl_match (
        .ways    (mem[fl_set]),
        .tag     (tag_of(fl_vpn)),
        .hit_vec (fl_match_vec),
        .hit     (fl_any),
        .ppn     (fl_unused_ppn),
        .perm    (fl_unused_perm)
    );

    tlb_victim_pick i_pick (
        .valid_vec (fl_valid_vec),
        .match_vec (fl_match_vec),
        .rr_ptr    (rr_ptr[fl_set]),
        .way       (fl_way),
        .advance   (fl_adv)
    );

    always_comb begin
        fl_entry.valid = 1'b1;
        fl_entry.tag   = tag_of(fl_vpn);
        fl_entry.ppn   = fl_ppn;
        fl_entry.perm  = perm_t'(fl_perm);
    end

    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            for (int s = 0; s < SETS; s++) begin
                mem[s]    <= '0;
                rr_ptr[s] <= '0;
            end
        end else if (fl_en) begin
            mem[fl_set][fl_way] <= fl_entry;
            if (fl_adv) rr_ptr[fl_set] <= rr_ptr[fl_set] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
`timescale 1ns/1ps
module tlb_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic [2:0]       lk_perm,
    input logic             fl_en,
    input logic [VPN_W-1:0] fl_vpn,
    input logic [PPN_W-1:0] fl_ppn,
    input logic [2:0]       fl_perm,
    input logic             flush_all,
    input logic [WAYS-1:0]  lk_hit_vec
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit); // R1

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !flush_all) |=> (lk_vpn != $past(fl_vpn)) ||
            (lk_hit && lk_ppn == $past(fl_ppn) && lk_perm == $past(fl_perm))); // R4

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec)); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !lk_hit); // R9 R10

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !fl_en && !flush_all) && $stable(lk_vpn))
            |-> ($stable(lk_hit) && $stable(lk_ppn))); // R11
endmodule

bind vpn_xlate_tlb tlb_checker i_tlb_checker (
    .clk        (clk),
    .rst        (rst),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_perm    (lk_perm),
    .fl_en      (fl_en),
    .fl_vpn     (fl_vpn),
    .fl_ppn     (fl_ppn),
    .fl_perm    (fl_perm),
    .flush_all  (flush_all),
    .lk_hit_vec (lk_hit_vec)
);

// File: tb/test_vpn_xlate_tlb.sv
`timescale 1ns/1ps
module test_vpn_xlate_tlb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lk_vpn = '0;
    logic       lk_hit;
    logic [5:0] lk_ppn;
    logic [2:0] lk_perm;
    logic       fl_en = 1'b0;
    logic [7:0] fl_vpn = '0;
    logic [5:0] fl_ppn = '0;
    logic [2:0] fl_perm = '0;
    logic       flush_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vpn_xlate_tlb i_vpn_xlate_tlb (
        .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_perm(lk_perm), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
        .fl_perm(fl_perm), .flush_all(flush_all)
    );

    function automatic logic [7:0] mk(input logic [5:0] tag, input logic [1:0] set);
        return {tag, set};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_hit(input string req, input logic [7:0] vpn,
                              input logic [5:0] ppn, input logic [2:0] perm);
        lk_vpn = vpn;
        #1;
        check(req, {22'd0, lk_hit, lk_ppn, lk_perm}, {22'd0, 1'b1, ppn, perm});
    endtask

    task automatic expect_miss(input string req, input logic [7:0] vpn);
        lk_vpn = vpn;
        #1;
        check(req, {22'd0, lk_hit, lk_ppn, lk_perm}, 32'd0);
    endtask

    task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic [2:0] perm);
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = vpn; fl_ppn = ppn; fl_perm = perm;
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic t_reset();
        expect_miss("R1 reset", mk(6'h00, 2'd0));
        expect_miss("R1 reset", mk(6'h3F, 2'd3));
    endtask

    task automatic t_basic();
        fill(mk(6'h0F, 2'd1), 6'h2D, 3'b101);
        expect_hit("R3 R4 hit data", mk(6'h0F, 2'd1), 6'h2D, 3'b101);
        expect_miss("R11 other vpn", mk(6'h0E, 2'd1));
        expect_hit("R11 comb follow", mk(6'h0F, 2'd1), 6'h2D, 3'b101);
        expect_miss("R5 tag mismatch", mk(6'h1F, 2'd1));
        expect_miss("R1 miss zero", mk(6'h0F, 2'd2));
    endtask

    task automatic t_sets();
        flush();
        for (int s = 0; s < 4; s++) fill(mk(6'h09, 2'(s)), 6'(6'h10 + s), 3'(s + 1));
        for (int s = 0; s < 4; s++)
            expect_hit("R2 same tag per set", mk(6'h09, 2'(s)), 6'(6'h10 + s), 3'(s + 1));
    endtask

    task automatic t_invalid_first();
        flush();
        for (int t = 0; t < 4; t++) fill(mk(6'(t + 1), 2'd1), 6'(t + 1), 3'b100);
        for (int t = 0; t < 4; t++)
            expect_hit("R6 all four resident", mk(6'(t + 1), 2'd1), 6'(t + 1), 3'b100);
    endtask

    task automatic t_round_robin();
        // set 1 full with tags 1..4 from t_invalid_first
        fill(mk(6'h05, 2'd1), 6'h05, 3'b110);
        expect_miss("R7 oldest evicted", mk(6'h01, 2'd1));
        expect_hit("R7 keep", mk(6'h02, 2'd1), 6'h02, 3'b100);
        expect_hit("R7 new", mk(6'h05, 2'd1), 6'h05, 3'b110);
        fill(mk(6'h06, 2'd1), 6'h06, 3'b010);
        expect_miss("R7 second evicted", mk(6'h02, 2'd1));
        expect_hit("R7 keep", mk(6'h03, 2'd1), 6'h03, 3'b100);
        expect_hit("R7 keep", mk(6'h05, 2'd1), 6'h05, 3'b110);
        // pointer now at way 2; flush must return it to way 0
        flush();
        expect_miss("R9 flushed", mk(6'h05, 2'd1));
        for (int t = 0; t < 4; t++) fill(mk(6'(t + 8), 2'd1), 6'(t + 8), 3'b001);
        fill(mk(6'h20, 2'd1), 6'h20, 3'b111);
        expect_miss("R9 pointer reset", mk(6'h08, 2'd1));
        expect_hit("R9 pointer reset", mk(6'h0A, 2'd1), 6'h0A, 3'b001);
    endtask

    task automatic t_refill();
        flush();
        for (int t = 0; t < 4; t++) fill(mk(6'(t + 16), 2'd2), 6'(t + 16), 3'b100);
        fill(mk(6'h12, 2'd2), 6'h3A, 3'b011);
        expect_hit("R8 overwritten", mk(6'h12, 2'd2), 6'h3A, 3'b011);
        expect_hit("R8 no eviction", mk(6'h10, 2'd2), 6'h10, 3'b100);
        expect_hit("R8 no eviction", mk(6'h11, 2'd2), 6'h11, 3'b100);
        expect_hit("R8 no eviction", mk(6'h13, 2'd2), 6'h13, 3'b100);
        fill(mk(6'h30, 2'd2), 6'h30, 3'b101);
        expect_miss("R8 pointer held", mk(6'h10, 2'd2));
        expect_hit("R8 pointer held", mk(6'h11, 2'd2), 6'h11, 3'b100);
    endtask

    task automatic t_flush_priority();
        fill(mk(6'h22, 2'd3), 6'h22, 3'b100);
        expect_hit("R10 setup", mk(6'h22, 2'd3), 6'h22, 3'b100);
        @(negedge clk);
        flush_all = 1'b1;
        fl_en = 1'b1; fl_vpn = mk(6'h23, 2'd3); fl_ppn = 6'h23; fl_perm = 3'b111;
        @(negedge clk);
        flush_all = 1'b0; fl_en = 1'b0;
        expect_miss("R10 fill dropped", mk(6'h23, 2'd3));
        expect_miss("R9 old entry gone", mk(6'h22, 2'd3));
        expect_miss("R9 other set gone", mk(6'h30, 2'd2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_sets();
        t_invalid_first();
        t_round_robin();
        t_refill();
        t_flush_priority();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule